// File: doc/BRIEF.md
# Reset Pulse and Cause Controller

This block turns short reset requests into reset pulses of programmable length. It accepts three requests: a general software reset, a software reset aimed at the protocol domain, and a watchdog reset. When any of them is seen, the block asserts a core reset output and holds it for `8*n + 8` clock cycles. `n` is a 16-bit duration field that software writes over an APB register port. With a 125 MHz clock, `n = 1562` gives roughly the 100 µs that attached PHYs need.

Four domain reset outputs follow the same pulse, but only for the domains whose enable bit is set. The pulse does not clear these enables, so a chosen set of domains is reset again on every later trigger.

A one-hot cause register records what caused the latest reset: the watchdog, a software request, or power-on. Only the bit for the newest event is set. Reset outputs go active combinationally as soon as a request appears. They are released on a clock edge once the count runs out. A request that arrives during a pulse starts the count again.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_n` and all `dom_rst_n` bits are 0. After power-on, the cause register reads 0x4, the duration field reads 0 and the domain enables read 0.
- R2: Take the clock edge that samples a request while no further request follows. From that edge, `core_rst_n` stays 0 for exactly `8*n + 8` clock cycles and then returns to 1. Here `n` is the duration field.
- R3: The duration field is read and written at offset 0x0C, bits 31:16. Bits 15:0 of that register read 0.
- R4: Each of the three requests `sw_req`, `proto_req` and `wdog_req` starts a pulse.
- R5: The domain enables sit at offset 0x10, bits 3:0. During a pulse, `dom_rst_n[i]` is 0 exactly when enable bit `i` is 1, and all bits are 1 otherwise.
- R6: A pulse does not change the domain enables or the duration field.
- R7: The cause register at offset 0x14 always has exactly one bit set. Bit 0 means watchdog, bit 1 means software (either software request) and bit 2 means power-on. Each new request leaves only its own bit set. If the watchdog request coincides with a software request, the watchdog bit wins.
- R8: A request seen during an active pulse restarts the count, so the pulse ends `8*n + 8` cycles after the last request edge. The cause register is updated to the new event.
- R9: The reset outputs go to 0 as soon as a request input rises, before any clock edge.
- R10: `pready` is always 1 and `pslverr` is always 0. Writes to 0x14 or to an undefined offset change nothing, and reads of undefined offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock; also times the pulse |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant 1 |
| pslverr | output | 1 | APB error, constant 0 |
| sw_req | input | 1 | Software reset request |
| proto_req | input | 1 | Protocol-domain software reset request |
| wdog_req | input | 1 | Watchdog reset request |
| core_rst_n | output | 1 | Core reset, active low |
| dom_rst_n | output | 4 | Per-domain resets, active low, gated by the enables |

## Verification
The hardest case to reach is a second request landing in the middle of a running pulse. The count must restart from the full length, not continue from where it was, and the cause bits must switch to the new event. The bench fires a software request and waits a few cycles. It then fires a watchdog request while the pulse is still active and measures the low time from the second request edge, expecting the full `8*n + 8` cycles. It also fires the watchdog and software requests in the same cycle to check the priority, and probes the outputs one time step after a request rises, before any clock edge.

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl #(
  parameter int DUR_W = 16,
  parameter int N_DOM = 4,
  parameter int AW    = 8
) (
  input  logic             pclk,
  input  logic             por_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic             sw_req,
  input  logic             proto_req,
  input  logic             wdog_req,
  output logic             core_rst_n,
  output logic [N_DOM-1:0] dom_rst_n
);
  localparam int CNT_W = DUR_W + 3;
  localparam logic [AW-1:0] A_DUR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_EN   = AW'(8'h10);
  localparam logic [AW-1:0] A_CAUS = AW'(8'h14);

  logic [DUR_W-1:0] dur;
  logic [N_DOM-1:0] en;
  logic [2:0]       cause;
  logic [CNT_W-1:0] cnt;
  logic             active;

  wire apb_wr  = psel & penable & pwrite;
  wire req_any = sw_req | proto_req | wdog_req;
  wire hit     = active | req_any;

  assign pready     = 1'b1;
  assign pslverr    = 1'b0;
  assign core_rst_n = por_n & ~hit;
  assign dom_rst_n  = {N_DOM{por_n}} & ~({N_DOM{hit}} & en);

  always_ff @(posedge pclk or negedge por_n) begin
    if (!por_n) begin
      dur <= '0;
      en  <= '0;
    end else if (apb_wr) begin
      if (paddr == A_DUR) dur <= pwdata[16 +: DUR_W];
      if (paddr == A_EN)  en  <= pwdata[N_DOM-1:0];
    end
  end

  always_ff @(posedge pclk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (req_any) begin
      active <= 1'b1;
      cnt    <= {dur, 3'b111};
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge pclk or negedge por_n) begin
    if (!por_n)                 cause <= 3'b100;
    else if (wdog_req)          cause <= 3'b001;
    else if (sw_req | proto_req) cause <= 3'b010;
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_DUR)       prdata = 32'({dur, 16'h0000});
    else if (paddr == A_EN)   prdata = 32'(en);
    else if (paddr == A_CAUS) prdata = 32'(cause);
  end

  p_req_starts_r4: assert property (@(posedge pclk) disable iff (!por_n)
    req_any |=> !core_rst_n);
  p_hold_r2: assert property (@(posedge pclk) disable iff (!por_n)
    (active && cnt != '0) |=> !core_rst_n);
  p_release_r2: assert property (@(posedge pclk) disable iff (!por_n)
    (active && cnt == '0 && !req_any) |=> active == 1'b0);
  p_restart_r8: assert property (@(posedge pclk) disable iff (!por_n)
    (active && req_any) |=> cnt == {dur, 3'b111});
  p_cause_onehot_r7: assert property (@(posedge pclk) disable iff (!por_n)
    $countones(cause) == 1);
  p_en_kept_r6: assert property (@(posedge pclk) disable iff (!por_n)
    !apb_wr |=> ($stable(en) && $stable(dur)));
  p_cause_ro_r10: assert property (@(posedge pclk) disable iff (!por_n)
    (apb_wr && !req_any) |=> $stable(cause));
endmodule

// File: tb/rst_pulse_ctrl_bench.sv
module rst_pulse_ctrl_bench;
  logic        pclk = 1'b0;
  logic        por_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        sw_req = 1'b0, proto_req = 1'b0, wdog_req = 1'b0;
  logic        core_rst_n;
  logic [3:0]  dom_rst_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 pclk = ~pclk;

  rst_pulse_ctrl u_rst_pulse_ctrl (
    .pclk(pclk), .por_n(por_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .sw_req(sw_req), .proto_req(proto_req),
    .wdog_req(wdog_req), .core_rst_n(core_rst_n), .dom_rst_n(dom_rst_n));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_write(logic [7:0] a, logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // which: 0 sw, 1 proto, 2 wdog, 3 wdog+sw
  task automatic fire(int which);
    @(negedge pclk);
    sw_req    = (which == 0 || which == 3);
    proto_req = (which == 1);
    wdog_req  = (which >= 2);
    #1 check("R9 async core", 32'(core_rst_n), 32'd0);
    @(negedge pclk);
    sw_req = 1'b0; proto_req = 1'b0; wdog_req = 1'b0;
  endtask

  task automatic count_low(output int len);
    len = 0;
    while (!core_rst_n && len < 100000) begin
      len++;
      @(negedge pclk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 check("R1 core during por", 32'(core_rst_n), 32'd0);
    check("R1 dom during por", 32'(dom_rst_n), 32'h0);
    @(negedge pclk); por_n = 1'b1;
    #1 check("R1 core after por", 32'(core_rst_n), 32'd1);
    check("R10 pslverr", 32'(pslverr), 32'd0);
    check("R10 pready", 32'(pready), 32'd1);
    apb_read(8'h14, d); check("R1 cause por", d, 32'h4);
    apb_read(8'h0C, d); check("R1 duration", d, 32'h0);
    apb_read(8'h10, d); check("R1 enables", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    apb_write(8'h0C, 32'h1234_FFFF);
    apb_read(8'h0C, d); check("R3 duration field", d, 32'h1234_0000);
    apb_write(8'h14, 32'h1);
    apb_read(8'h14, d); check("R10 cause write ignored", d, 32'h4);
    apb_write(8'h20, 32'hFFFF_FFFF);
    apb_read(8'h20, d); check("R10 undefined read", d, 32'h0);
    apb_read(8'h0C, d); check("R10 duration untouched", d, 32'h1234_0000);
    apb_read(8'h10, d); check("R10 enables untouched", d, 32'h0);
  endtask

  task automatic t_pulse(int n, int which, logic [31:0] exp_cause);
    int len;
    logic [31:0] d;
    apb_write(8'h0C, 32'(n) << 16);
    fire(which);
    count_low(len);
    check($sformatf("R2 R4 length n=%0d src=%0d", n, which), 32'(len), 32'(8 * n + 8));
    apb_read(8'h14, d); check("R7 cause", d, exp_cause);
  endtask

  task automatic t_domains;
    logic [31:0] d;
    apb_write(8'h0C, 32'h0002_0000);
    apb_write(8'h10, 32'h5);
    @(negedge pclk); sw_req = 1'b1;
    @(negedge pclk); sw_req = 1'b0;
    check("R5 dom during pulse", 32'(dom_rst_n), 32'hA);
    repeat (30) @(negedge pclk);
    check("R5 dom after pulse", 32'(dom_rst_n), 32'hF);
    apb_read(8'h10, d); check("R6 enables retained", d, 32'h5);
    apb_read(8'h0C, d); check("R6 duration retained", d, 32'h0002_0000);
  endtask

  task automatic t_restart;
    int len;
    logic [31:0] d;
    apb_write(8'h0C, 32'h0003_0000);
    fire(0);
    repeat (4) @(negedge pclk);
    fire(2);
    count_low(len);
    check("R8 restarted length", 32'(len), 32'd32);
    apb_read(8'h14, d); check("R8 cause updated", d, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regs();
    t_pulse(0, 0, 32'h2);
    t_pulse(1, 1, 32'h2);
    t_pulse(3, 2, 32'h1);
    t_pulse(2, 3, 32'h1);
    t_pulse(1562, 0, 32'h2);
    t_domains();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule